// File: doc/BRIEF.md
# Accumulate-Source Prefetch Engine

This block runs the accumulate phase of one output polynomial in a matrix-vector product over coefficients modulo 3329. For output row `i` and column `j`, a separate multiplier delivers product coefficients one by one. The block adds to each product a source coefficient and writes the sum back into the public-vector bank at row `i`. For the first column the source is the error polynomial that sits at relative slot `K+i` of the secret/error bank. For any later column the source is the partial sum already stored in the public-vector bank at row `i`.

Both banks have a registered read port, and products arrive at an irregular rate (typically a repeating idle, valid, valid pattern). The engine therefore reads sources ahead into a two-entry skid buffer. Its read index only increases and always stays ahead of the write index, so one pass never reads a coefficient it has already rewritten. Both banks sit inside the block and have plain fill ports. These ports are live only while the engine is idle.

Top module: `acc_prefetch_top`

## Requirements
- R1: After reset, `busy`, `done`, `src_rdy` and `t_wr_en` are all low.
- R2: When `col_sel` is 0, the source for coefficient n is secret/error bank word `(k_rows + row_sel)*N_COEF + n`.
- R3: When `col_sel` is non-zero, the source for coefficient n is public-vector bank word `row_sel*N_COEF + n`.
- R4: Each accepted product writes `(prod_coef + source) mod 3329` to public-vector word `row_sel*N_COEF + n`. The index n runs from 0 to N_COEF-1 in order, and the written value is always below 3329.
- R5: The buffered entries plus the read in flight never exceed two. `src_rdy` is high only while an entry is held. A `prod_valid` without `src_rdy` writes nothing.
- R6: At every write, the read index of the pass is strictly greater than the write index.
- R7: The results do not depend on the product cadence: a repeating 0,1,1 pattern, a valid on every cycle, and a valid every fourth cycle all give identical sums.
- R8: `done` is a one-cycle pulse in the cycle after the N_COEF-th write, and `busy` is low in that same cycle.
- R9: A `start` while `busy` is high is ignored: the row, column and K of the pass in progress are kept.
- R10: Fill writes to either bank are ignored while `busy` is high.
- R11: A public-vector read and a public-vector write in the same cycle are allowed, and the read returns the old value. A later pass with a non-zero column sees the sums written by the earlier pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass (accepted only when idle) |
| row_sel | input | RW | Output row i |
| col_sel | input | RW | Column j; zero selects the error source |
| k_rows | input | RW+1 | Matrix dimension K |
| prod_valid | input | 1 | Product coefficient is present |
| prod_coef | input | 12 | Product coefficient, below 3329 |
| src_rdy | output | 1 | A source coefficient is buffered |
| se_ld_en | input | 1 | Secret/error bank fill strobe |
| se_ld_addr | input | RW+1+NB | Secret/error bank fill address |
| se_ld_data | input | 12 | Secret/error bank fill data |
| t_ld_en | input | 1 | Public-vector bank fill strobe |
| t_ld_addr | input | RW+NB | Public-vector bank fill address |
| t_ld_data | input | 12 | Public-vector bank fill data |
| t_wr_en | output | 1 | Accumulated result written this cycle |
| t_wr_addr | output | RW+NB | Address of the result |
| t_wr_data | output | 12 | Accumulated result |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Pass-complete pulse |

## Verification
The bench builds the block with `N_COEF=16` and `KMAX=2`. A full pass then takes a few dozen cycles, and the whole 64-word secret/error bank and 32-word public-vector bank are filled from the ports and modelled in the bench. With these sizes, every source slot `K+i` for K of 1 and 2 can be reached, as can chained column passes on both rows and the three cadences. The fill data and products are chosen so that sums near twice the modulus exercise the wrap. A start and a fill issued during a pass are each checked later, by reading back the affected row through the normal pass interface.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int COEF_W = 12;

  typedef logic [COEF_W-1:0] coef_t;

  // modular sum of two reduced coefficients
  function automatic coef_t add_modq(input coef_t a, input coef_t b,
                                     input logic [COEF_W:0] q);
    logic [COEF_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= q) return coef_t'(s - q);
    return coef_t'(s);
  endfunction

endpackage

// File: rtl/acc_bank.sv
module acc_bank #(
  parameter int AW = 10,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // one process: a same-address read captures the pre-write word
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
  end
endmodule

// File: rtl/acc_skid.sv
module acc_skid #(
  parameter int DW    = 12,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          nonempty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] slot [DEPTH];
  logic [PW-1:0] wptr, rptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) slot[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign head     = slot[rptr];
  assign nonempty = (count != '0);
endmodule

// File: rtl/acc_prefetch.sv
module acc_prefetch #(
  parameter int N_COEF = 256,
  parameter int DEPTH  = 2,
  parameter int DW     = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        active,
  input  logic                        pop,
  input  logic [DW-1:0]               rd_data,
  output logic                        issue,
  output logic [$clog2(N_COEF)-1:0]   rd_idx,
  output logic [$clog2(N_COEF):0]     rd_ptr,
  output logic [DW-1:0]               head,
  output logic                        head_valid,
  output logic [$clog2(DEPTH+1):0]    occ
);
  localparam int NB = $clog2(N_COEF);
  localparam int CW = $clog2(DEPTH+1);
  localparam int OW = CW + 1;

  logic          inflight;
  logic [CW-1:0] count;
  logic          reads_left;

  assign reads_left = (rd_ptr != (NB+1)'(N_COEF));
  assign occ        = OW'(count) + OW'(inflight);
  assign issue      = active && !clear && reads_left &&
                      ((occ < OW'(DEPTH)) || pop);
  assign rd_idx     = rd_ptr[NB-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      inflight <= 1'b0;
    end else begin
      inflight <= issue;
      if (clear)      rd_ptr <= '0;
      else if (issue) rd_ptr <= rd_ptr + (NB+1)'(1);
    end
  end

  acc_skid #(.DW(DW), .DEPTH(DEPTH)) u_skid (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (inflight),
    .din      (rd_data),
    .pop      (pop),
    .head     (head),
    .nonempty (head_valid),
    .count    (count)
  );
endmodule

// File: rtl/acc_prefetch_top.sv
module acc_prefetch_top
  import acc_pkg::*;
#(
  parameter int N_COEF = 256,
  parameter int KMAX   = 4,
  parameter int Q      = 3329,
  parameter int SKID   = 2,
  localparam int NB    = $clog2(N_COEF),
  localparam int RW    = $clog2(KMAX),
  localparam int SE_AW = RW + 1 + NB,
  localparam int T_AW  = RW + NB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RW-1:0]     row_sel,
  input  logic [RW-1:0]     col_sel,
  input  logic [RW:0]       k_rows,
  input  logic              prod_valid,
  input  logic [COEF_W-1:0] prod_coef,
  output logic              src_rdy,
  input  logic              se_ld_en,
  input  logic [SE_AW-1:0]  se_ld_addr,
  input  logic [COEF_W-1:0] se_ld_data,
  input  logic              t_ld_en,
  input  logic [T_AW-1:0]   t_ld_addr,
  input  logic [COEF_W-1:0] t_ld_data,
  output logic              t_wr_en,
  output logic [T_AW-1:0]   t_wr_addr,
  output logic [COEF_W-1:0] t_wr_data,
  output logic              busy,
  output logic              done
);
  localparam logic [COEF_W:0] QV = (COEF_W+1)'(Q);

  // pass state
  logic [RW-1:0] row_q;
  logic [RW:0]   k_q;
  logic          from_t_q;
  logic [NB:0]   wr_cnt;

  // named events
  logic start_acc, wr_fire, last_wr;
  logic issue;
  logic [NB-1:0] rd_idx;
  logic [NB:0]   rd_ptr;
  logic [COEF_W-1:0] head, src_data;
  logic head_valid;
  logic [$clog2(SKID+1):0] occ;

  // bank wires
  logic [SE_AW-1:0]  se_rd_addr;
  logic [COEF_W-1:0] se_rd_data, t_rd_data;
  logic [T_AW-1:0]   t_rd_addr, t_bank_waddr;
  logic [COEF_W-1:0] t_bank_wdata;
  logic              t_bank_we, se_rd_en, t_rd_en;
  logic [RW:0]       se_slot;

  assign start_acc = start && !busy;
  assign wr_fire   = busy && prod_valid && head_valid;
  assign last_wr   = wr_fire && (wr_cnt == (NB+1)'(N_COEF-1));
  assign src_rdy   = head_valid;

  // source addressing: error slot K+i or partial sum at row i
  assign se_slot    = k_q + {1'b0, row_q};
  assign se_rd_addr = {se_slot, rd_idx};
  assign t_rd_addr  = {row_q, rd_idx};
  assign se_rd_en   = issue && !from_t_q;
  assign t_rd_en    = issue && from_t_q;
  assign src_data   = from_t_q ? t_rd_data : se_rd_data;

  // result path
  assign t_wr_en   = wr_fire;
  assign t_wr_addr = {row_q, wr_cnt[NB-1:0]};
  assign t_wr_data = add_modq(prod_coef, head, QV);

  // public-vector write port: engine while busy, fill otherwise
  assign t_bank_we    = busy ? wr_fire   : t_ld_en;
  assign t_bank_waddr = busy ? t_wr_addr : t_ld_addr;
  assign t_bank_wdata = busy ? t_wr_data : t_ld_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      row_q    <= '0;
      k_q      <= '0;
      from_t_q <= 1'b0;
      wr_cnt   <= '0;
    end else begin
      done <= last_wr;
      if (start_acc) begin
        busy     <= 1'b1;
        row_q    <= row_sel;
        k_q      <= k_rows;
        from_t_q <= (col_sel != '0);
        wr_cnt   <= '0;
      end else if (wr_fire) begin
        wr_cnt <= wr_cnt + (NB+1)'(1);
        if (last_wr) busy <= 1'b0;
      end
    end
  end

  acc_prefetch #(.N_COEF(N_COEF), .DEPTH(SKID), .DW(COEF_W)) u_pref (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_acc),
    .active     (busy),
    .pop        (wr_fire),
    .rd_data    (src_data),
    .issue      (issue),
    .rd_idx     (rd_idx),
    .rd_ptr     (rd_ptr),
    .head       (head),
    .head_valid (head_valid),
    .occ        (occ)
  );

  acc_bank #(.AW(SE_AW), .DW(COEF_W)) u_se_bank (
    .clk     (clk),
    .rd_en   (se_rd_en),
    .rd_addr (se_rd_addr),
    .rd_data (se_rd_data),
    .wr_en   (se_ld_en && !busy),
    .wr_addr (se_ld_addr),
    .wr_data (se_ld_data)
  );

  acc_bank #(.AW(T_AW), .DW(COEF_W)) u_t_bank (
    .clk     (clk),
    .rd_en   (t_rd_en),
    .rd_addr (t_rd_addr),
    .rd_data (t_rd_data),
    .wr_en   (t_bank_we),
    .wr_addr (t_bank_waddr),
    .wr_data (t_bank_wdata)
  );
endmodule

// File: rtl/acc_prefetch_chk.sv
module acc_prefetch_chk #(
  parameter int NB   = 8,
  parameter int RW   = 2,
  parameter int OW   = 3,
  parameter int SKID = 2,
  parameter int Q    = 3329
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          t_wr_en,
  input logic [11:0]   t_wr_data,
  input logic [NB:0]   rd_ptr,
  input logic [NB:0]   wr_cnt,
  input logic [OW-1:0] occ,
  input logic [RW-1:0] row_q
);
  // R5
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(SKID));

  // R5
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !t_wr_en);

  // R6
  read_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_wr_en |-> (rd_ptr > wr_cnt));

  // R4
  data_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_wr_en |-> (t_wr_data < 12'(Q)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(t_wr_en)));

  // R9
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(row_q));
endmodule

bind acc_prefetch_top acc_prefetch_chk #(
  .NB($clog2(N_COEF)), .RW($clog2(KMAX)), .OW($clog2(SKID+1)+1),
  .SKID(SKID), .Q(Q)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .t_wr_en   (t_wr_en),
  .t_wr_data (t_wr_data),
  .rd_ptr    (rd_ptr),
  .wr_cnt    (wr_cnt),
  .occ       (occ),
  .row_q     (row_q)
);

// File: tb/acc_prefetch_top_tb.sv
module acc_prefetch_top_tb;
  localparam int N    = 16;
  localparam int KM   = 2;
  localparam int Q    = 3329;
  localparam int RW   = 1;
  localparam int SEAW = 6;
  localparam int TAW  = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [RW-1:0] row_sel = 0, col_sel = 0;
  logic [RW:0] k_rows = 0;
  logic prod_valid = 0;
  logic [11:0] prod_coef = 0;
  logic src_rdy;
  logic se_ld_en = 0;
  logic [SEAW-1:0] se_ld_addr = 0;
  logic [11:0] se_ld_data = 0;
  logic t_ld_en = 0;
  logic [TAW-1:0] t_ld_addr = 0;
  logic [11:0] t_ld_data = 0;
  logic t_wr_en;
  logic [TAW-1:0] t_wr_addr;
  logic [11:0] t_wr_data;
  logic busy, done;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int se_m [64];
  int t_m [32];

  // {row, col, k, cadence}; cadence 0: 0,1,1  1: every cycle  2: one in four
  localparam logic [31:0] PASS_TAB [6] = '{
    {8'd0, 8'd0, 8'd2, 8'd0},
    {8'd1, 8'd0, 8'd2, 8'd1},
    {8'd0, 8'd1, 8'd2, 8'd0},
    {8'd1, 8'd1, 8'd2, 8'd2},
    {8'd0, 8'd0, 8'd1, 8'd0},
    {8'd1, 8'd1, 8'd1, 8'd1}
  };

  always #4 clk = ~clk;  // 125 MHz

  acc_prefetch_top #(.N_COEF(N), .KMAX(KM), .Q(Q)) u_dut (.*);

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int prod_of(input int p, input int n);
    return (p * 517 + n * 211 + 3000) % Q;
  endfunction

  task automatic run_pass(input int row, input int col, input int k,
                          input int mode, input int pid, input bit inj);
    int n = 0;
    int c = 0;
    bit injected = 0;
    bit v;
    @(negedge clk);
    row_sel = RW'(row); col_sel = RW'(col); k_rows = (RW+1)'(k); start = 1;
    @(negedge clk);
    start = 0;
    while (n < N) begin
      v = (mode == 0) ? (c % 3 != 0) : (mode == 1) ? 1'b1 : (c % 4 == 3);
      c++;
      prod_valid = v;
      prod_coef  = 12'(prod_of(pid, n));
      if (inj && n == 5 && !injected) begin
        injected  = 1;
        start     = 1;            // R9 start while busy
        row_sel   = RW'(row ^ 1);
        col_sel   = 0;
        t_ld_en   = 1;            // R10 fill while busy
        t_ld_addr = TAW'(((row ^ 1) * N) + 3);
        t_ld_data = 12'd7;
      end
      #1;
      if (v && src_rdy) begin
        int src = (col == 0) ? se_m[(k + row) * N + n] : t_m[row * N + n];
        int exp = (prod_of(pid, n) + src) % Q;
        check(col == 0 ? "R2/R4 data" : "R3/R11 data", int'(t_wr_data), exp);
        check("R4 addr", int'(t_wr_addr), row * N + n);
        check("R7 write strobe", int'(t_wr_en), 1);
        t_m[row * N + n] = exp;
        n++;
      end else if (v) begin
        check("R5 no write without src_rdy", int'(t_wr_en), 0);
      end
      @(negedge clk);
      prod_valid = 0; start = 0; t_ld_en = 0;
    end
    check("R8 done pulse", int'(done), 1);
    check("R8 busy low at done", int'(busy), 0);
    @(negedge clk);
    check("R8 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 src_rdy", int'(src_rdy), 0);
    check("R1 t_wr_en", int'(t_wr_en), 0);
    rst_n = 1;

    for (int a = 0; a < 64; a++) begin
      se_m[a] = (a * 733 + 3100) % Q;
      @(negedge clk);
      se_ld_en = 1; se_ld_addr = SEAW'(a); se_ld_data = 12'(se_m[a]);
    end
    for (int a = 0; a < 32; a++) begin
      t_m[a] = (a * 389 + 3200) % Q;
      @(negedge clk);
      se_ld_en = 0;
      t_ld_en = 1; t_ld_addr = TAW'(a); t_ld_data = 12'(t_m[a]);
    end
    @(negedge clk);
    t_ld_en = 0;

    // table walk: R2 R3 R7 R11 across cadences and K values
    for (int p = 0; p < 6; p++) begin
      run_pass(int'(PASS_TAB[p][31:24]), int'(PASS_TAB[p][23:16]),
               int'(PASS_TAB[p][15:8]), int'(PASS_TAB[p][7:0]), p, 0);
    end

    // R9 R10: start and fill during a pass on row 0; row 1 must be untouched
    run_pass(0, 1, 2, 0, 6, 1);
    // readback of row 1 partial sums (incl. word 3) through a column pass
    run_pass(1, 1, 2, 1, 7, 0);

    // R5: product offered right after start, before any source arrives
    @(negedge clk);
    row_sel = 0; col_sel = 0; k_rows = 2; start = 1;
    @(negedge clk);
    start = 0; prod_valid = 1; prod_coef = 12'd5;
    #1;
    check("R5 src_rdy low at pass start", int'(src_rdy), 0);
    check("R5 write suppressed", int'(t_wr_en), 0);
    @(negedge clk);
    prod_valid = 0;
    // finish this pass with a full-rate producer
    for (int n = 0; n < N; ) begin
      @(negedge clk);
      prod_valid = 1; prod_coef = 12'(prod_of(8, n));
      #1;
      if (src_rdy) begin
        check("R2 data", int'(t_wr_data), (prod_of(8, n) + se_m[2 * N + n]) % Q);
        t_m[n] = (prod_of(8, n) + se_m[2 * N + n]) % Q;
        n++;
      end
    end
    @(negedge clk);
    prod_valid = 0;
    check("R8 done", int'(done), 1);
    run_pass(0, 1, 2, 2, 9, 0);
    summary();
  end
endmodule